// File: doc/BRIEF.md
# Parallel-Prefix Magnitude Comparator

This block compares two unsigned operands of a configurable width and raises exactly one of three flags: first operand greater, first operand less, or both equal. It is purely combinational. Its result follows its inputs in the same cycle, with no clock and no state, so it can sit inside a compare-and-exchange cell of a sorting network or any datapath that needs an ordering decision.

The comparison is not done by subtraction. A row of XOR cells marks every bit position where the operands differ. The marks are folded with NOR logic into per-group "still equal" terms, and those terms are widened into a prefix for each bit position. NAND cells then find the single highest position that differs and has no difference above it. Only that position's operand bit pair is steered through a 2-bit multiplexer; every other position passes zeros. Two OR reductions over the steered pairs give the decision.

Top module: `prefix_mag_cmp`

## Requirements
- R1: `a_gt` is 1 exactly when `opa` is greater than `opb` as unsigned numbers.
- R2: `a_lt` is 1 exactly when `opa` is less than `opb` as unsigned numbers.
- R3: `a_eq` is 1 exactly when `opa` and `opb` are bit-for-bit identical.
- R4: At any input pair, exactly one of `a_gt`, `a_lt`, `a_eq` is 1.
- R5: When the operands first differ at bit position k (counting from the MSB down), the values of all bits below k in either operand have no effect on any output.
- R6: The outputs depend only on the present inputs and settle within the same cycle the inputs change, with no clock and no retained state.
- R7: At most one bit position forwards a non-zero operand pair to the decision stage, and that position is the highest one where the operands differ.
- R8: `WIDTH` must be a non-zero multiple of the group size 4; any other value is rejected at elaboration.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | First unsigned operand |
| opb | input | WIDTH | Second unsigned operand |
| a_gt | output | 1 | `opa` is greater than `opb` |
| a_lt | output | 1 | `opa` is less than `opb` |
| a_eq | output | 1 | Operands are equal |

## Verification
The bench sweeps every pair of 8-bit operands, so every position of the first difference and every pattern of lower bits under it is covered. It also checks named corners. The first is a difference only in the MSB with the lower bits set against the decision; a prefix that leaks lower positions would raise both `a_gt` and `a_lt`. The second is a difference only in the LSB, which shows whether the prefix clears all the way down; a wrong prefix there reports equal. The third is a difference that straddles the bit 3 / bit 4 group boundary, where a broken set-3 fold between groups lets the lower group override the upper one. All-ones against all-zeros checks both extreme values.

// File: rtl/prefix_cmp_pkg.sv
package prefix_cmp_pkg;
   localparam int unsigned GRP = 4;
   typedef struct packed {
      logic gt;
      logic lt;
      logic eq;
   } cmp_flags_t;
endpackage

// File: rtl/pfx_diff_row.sv
module pfx_diff_row #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic [WIDTH-1:0] diff
);
   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      assign diff[k] = opa[k] ^ opb[k];
   end
endmodule

// File: rtl/pfx_clear_tree.sv
module pfx_clear_tree
   import prefix_cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] diff,
   output logic [WIDTH-1:0] clr_above
);
   localparam int unsigned NG = WIDTH / GRP;

   logic [NG-1:0] grp_same;
   logic [NG-1:0] grp_clear;

   // group NOR terms
   for (genvar g = 0; g < NG; g++) begin : g_grp
      assign grp_same[g] = ~|diff[g*GRP +: GRP];
      if (g == NG - 1) begin : g_top
         assign grp_clear[g] = 1'b1;
      end else begin : g_low
         assign grp_clear[g] = &grp_same[NG-1:g+1];
      end
   end

   // per-bit prefix: upper groups clear and no higher bit in own group differs
   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      localparam int unsigned G   = k / GRP;
      localparam int unsigned TOP = G * GRP + GRP - 1;
      if (k == TOP) begin : g_head
         assign clr_above[k] = grp_clear[G];
      end else begin : g_body
         assign clr_above[k] = grp_clear[G] & ~|diff[TOP:k+1];
      end
   end
endmodule

// File: rtl/pfx_gate_row.sv
module pfx_gate_row #(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic [WIDTH-1:0] diff,
   input  logic [WIDTH-1:0] clr_above,
   output logic [WIDTH-1:0] pass_a,
   output logic [WIDTH-1:0] pass_b
);
   for (genvar k = 0; k < WIDTH; k++) begin : g_bit
      logic blk_n;
      assign blk_n = ~(diff[k] & clr_above[k]);
      assign {pass_a[k], pass_b[k]} = blk_n ? 2'b00 : {opa[k], opb[k]};
   end
endmodule

// File: rtl/prefix_mag_cmp.sv
module prefix_mag_cmp
   import prefix_cmp_pkg::*;
#(
   parameter int unsigned WIDTH = 8
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   output logic             a_gt,
   output logic             a_lt,
   output logic             a_eq
);
   // R8: elaboration check on width
   if (WIDTH == 0 || (WIDTH % GRP) != 0) begin : g_bad_width
      $error("prefix_mag_cmp: WIDTH must be a non-zero multiple of 4");
   end

   logic [WIDTH-1:0] diff;
   logic [WIDTH-1:0] clr_above;
   logic [WIDTH-1:0] pass_a;
   logic [WIDTH-1:0] pass_b;
   cmp_flags_t       flags;

   pfx_diff_row #(.WIDTH(WIDTH)) u_diff (
      .opa  (opa),
      .opb  (opb),
      .diff (diff)
   );

   pfx_clear_tree #(.WIDTH(WIDTH)) u_tree (
      .diff      (diff),
      .clr_above (clr_above)
   );

   pfx_gate_row #(.WIDTH(WIDTH)) u_gate (
      .opa       (opa),
      .opb       (opb),
      .diff      (diff),
      .clr_above (clr_above),
      .pass_a    (pass_a),
      .pass_b    (pass_b)
   );

   // decision: two OR reductions
   always_comb begin
      flags.gt = |pass_a;
      flags.lt = |pass_b;
      flags.eq = ~(flags.gt | flags.lt);
   end

   assign a_gt = flags.gt;
   assign a_lt = flags.lt;
   assign a_eq = flags.eq;
endmodule

// File: rtl/prefix_mag_cmp_chk.sv
module prefix_mag_cmp_chk #(
   parameter int unsigned WIDTH = 8
) (
   input logic [WIDTH-1:0] opa,
   input logic [WIDTH-1:0] opb,
   input logic [WIDTH-1:0] pass_a,
   input logic [WIDTH-1:0] pass_b,
   input logic             a_gt,
   input logic             a_lt,
   input logic             a_eq
);
   always_comb begin
      a_r1_gt_order: assert (!a_gt || (opa > opb))
         else $error("R1 a_gt without opa>opb");
      a_r2_lt_order: assert (!a_lt || (opa < opb))
         else $error("R2 a_lt without opa<opb");
      a_r3_eq_match: assert (a_eq == (opa == opb))
         else $error("R3 a_eq mismatch");
      a_r4_one_flag: assert ($countones({a_gt, a_lt, a_eq}) == 1)
         else $error("R4 flags not one-hot");
      a_r7_single_pass: assert ($onehot0(pass_a | pass_b))
         else $error("R7 more than one position forwarded");
      a_r7_pair_differs: assert ((pass_a & pass_b) == '0)
         else $error("R7 forwarded pair does not differ");
   end
endmodule

bind prefix_mag_cmp prefix_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
   .opa    (opa),
   .opb    (opb),
   .pass_a (pass_a),
   .pass_b (pass_b),
   .a_gt   (a_gt),
   .a_lt   (a_lt),
   .a_eq   (a_eq)
);

// File: tb/sim_prefix_mag_cmp.sv
module sim_prefix_mag_cmp;
   localparam int W = 8;

   logic         clk = 1'b0;
   logic         rst = 1'b1;
   logic [W-1:0] opa = '0;
   logic [W-1:0] opb = '0;
   logic         a_gt, a_lt, a_eq;
   int           checks = 0;
   int           errors = 0;
   bit           done = 1'b0;

   always #4 clk = ~clk;

   prefix_mag_cmp #(.WIDTH(W)) u0 (
      .opa (opa), .opb (opb),
      .a_gt(a_gt), .a_lt(a_lt), .a_eq(a_eq)
   );

   task automatic chk(input string req, input logic [2:0] got, input logic [2:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s a=%0d b=%0d got gt/lt/eq=%b expected %b", req, opa, opb, got, exp);
      end
   endtask

   // drive on negedge, sample on following posedge
   task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input string req);
      @(negedge clk);
      opa = a;
      opb = b;
      @(posedge clk);
      chk(req, {a_gt, a_lt, a_eq}, {a > b, a < b, a == b});
   endtask

   initial begin
      int cyc = 0;
      while (!done && cyc < 150000) begin
         @(posedge clk);
         cyc++;
      end
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog expired: got timeout expected completion");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(posedge clk);
      // R6/R3: state with zero inputs right after reset, no clock dependency
      chk("R3 reset-state", {a_gt, a_lt, a_eq}, 3'b001);
      rst = 1'b0;
      // R6: change inputs mid-cycle, check after a short delay without an edge
      @(negedge clk);
      opa = 8'd9; opb = 8'd3;
      #1;
      chk("R6 same-cycle settle", {a_gt, a_lt, a_eq}, 3'b100);
      // R5: MSB difference, lower bits set against it
      apply(8'h80, 8'h7F, "R5 msb-only gt");
      apply(8'h7F, 8'h80, "R5 msb-only lt");
      // LSB-only difference
      apply(8'h01, 8'h00, "R1 lsb-only gt");
      apply(8'hFE, 8'hFF, "R2 lsb-only lt");
      // group boundary bit 4 vs bit 3
      apply(8'h10, 8'h0F, "R7 group-boundary gt");
      apply(8'h0F, 8'h10, "R7 group-boundary lt");
      // extremes
      apply(8'hFF, 8'h00, "R1 extremes gt");
      apply(8'h00, 8'hFF, "R2 extremes lt");
      apply(8'hFF, 8'hFF, "R3 all-ones eq");
      // exhaustive sweep; one-hot checked separately for R4
      for (int i = 0; i < 256; i++) begin
         for (int j = 0; j < 256; j++) begin
            apply(i[W-1:0], j[W-1:0], "R1/R2/R3 sweep");
            checks++;
            if ($countones({a_gt, a_lt, a_eq}) != 1) begin
               errors++;
               $display("FAIL R4 a=%0d b=%0d got %0d flags expected 1", i, j,
                        $countones({a_gt, a_lt, a_eq}));
            end
         end
      end
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule